// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block makes sure that an SDRAM gets enough auto-refresh commands, and it handles entry to and exit from low-power self refresh. An interval timer adds one owed refresh each average refresh period. The block turns that debt into command requests for a shared command arbiter, using a request/grant handshake. A refresh is only ever asked for while every bank is closed. If any bank is open, the block first asks for a precharge of all banks (address bit 10 high), then waits the precharge recovery time before it asks for the refresh.

The arbiter may keep the block waiting while it serves other traffic. Refreshes owed in the meantime accumulate up to a fixed limit, and reaching that limit raises an urgency flag so that the arbiter puts refresh ahead of everything else. A sleep request puts the memory into self refresh: the block asks for a refresh command and drives the clock-enable low on the same edge. When sleep is released, the block raises the clock-enable, waits one row cycle time, issues one auto refresh and only then hands the memory back for normal access. All clock counts are derived at elaboration from the clock frequency and the nanosecond timings.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, and after it is released with no stimulus, `cmdReq` is 0, `cmdKind` is 0, `refUrgent` is 0, `ckeOut` is 1 and `accessOk` is 1.
- R2: One refresh becomes owed every INTERVAL = floor(REFI_NS*CLK_MHZ/1000) clocks (1953 at defaults). With all banks closed, the first request after reset appears no earlier than INTERVAL and no later than INTERVAL+2 clocks after release, with `cmdKind` = 2 (auto refresh).
- R3: While any bank is open, no refresh is requested. The block instead requests a precharge of all banks, `cmdKind` = 1.
- R4: After a granted precharge-all, no refresh or self-refresh request appears before TRP = ceil(TRP_NS*CLK_MHZ/1000) clocks (3 at defaults) have passed.
- R5: After a granted auto refresh, `accessOk` and `cmdReq` stay low, and `accessOk` returns exactly TRC = ceil(TRC_NS*CLK_MHZ/1000) clocks (9 at defaults) after the grant cycle.
- R6: Ungranted refreshes accumulate up to DEBT_MAX (8). A tick that arrives while 8 are owed is dropped. `refUrgent` is high exactly while 8 are owed. Each granted refresh repays one, and the request stays raised while any remain owed.
- R7: A sleep request (with banks closed) produces a request with `cmdKind` = 3. `ckeOut` goes low in the cycle that request is granted and stays low while sleep is held, with no requests and `accessOk` low.
- R8: When sleep is released, `ckeOut` is high from the next cycle. A single auto-refresh request (`cmdKind` = 2) follows exactly TRC clocks after the clock-enable rises. `accessOk` stays low until TRC clocks after that refresh is granted, and no owed refresh remains afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| anyBankOpen | input | 1 | High while at least one bank holds an open row |
| sleepReq | input | 1 | High to enter and hold self refresh |
| cmdGrant | input | 1 | Arbiter issues the requested command on this edge |
| cmdReq | output | 1 | A command is requested |
| cmdKind | output | 2 | 0 none, 1 precharge-all, 2 auto refresh, 3 self-refresh entry |
| refUrgent | output | 1 | Refresh debt at its limit; refresh must win arbitration |
| ckeOut | output | 1 | Clock-enable to the memory |
| accessOk | output | 1 | Arbiter may schedule other traffic |

## Verification
A grant is issued on an edge, and its effects show in the cycle after it. A request appears two cycles after the tick or wait expiry that caused it, because the debt register and the state register each add one cycle. The precharge recovery therefore shows as a request TRP+1 samples after the grant, the row cycle time shows as `accessOk` returning on the TRC-th sample, and the exit refresh shows TRC samples after the clock-enable rises. The bench samples every output on the falling edge and counts falling edges from the cycle a grant or release takes effect. The only exception is the clock-enable drop: it follows the grant within the same cycle, so it is checked in the same cycle, after the grant is applied.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PREA = 2'd1,
    KIND_REF  = 2'd2,
    KIND_SRE  = 2'd3
  } cmdKind_e;

  typedef enum logic [1:0] {
    WAIT_NONE,
    WAIT_TRP,
    WAIT_TRC,
    WAIT_EXIT
  } waitSel_e;

  // strobes from control to the counters
  typedef struct packed {
    logic     debtDec;
    logic     holdClear;
    waitSel_e waitLoad;
  } ctlStrobes_t;

  function automatic int unsigned ceilClks(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/refsched_timers.sv
module refsched_timers
  import refsched_pkg::*;
#(
  parameter int unsigned INTERVAL_CLKS = 1953,
  parameter int unsigned DEBT_MAX      = 8,
  parameter int unsigned TRP_CLKS      = 3,
  parameter int unsigned TRC_CLKS      = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobe,
  output logic        debtPending,
  output logic        debtFull,
  output logic        waitDone
);

  localparam int IW = (INTERVAL_CLKS > 2) ? $clog2(INTERVAL_CLKS) : 1;
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int WW = $clog2(TRC_CLKS + 1);
  localparam logic [IW-1:0] INT_LAST = IW'(INTERVAL_CLKS - 1);
  localparam logic [DW-1:0] DEBT_TOP = DW'(DEBT_MAX);
  localparam logic [WW-1:0] LOAD_TRP = WW'((TRP_CLKS >= 2) ? TRP_CLKS - 2 : 0);
  localparam logic [WW-1:0] LOAD_TRC = WW'((TRC_CLKS >= 2) ? TRC_CLKS - 2 : 0);
  localparam logic [WW-1:0] LOAD_EXIT = WW'((TRC_CLKS >= 1) ? TRC_CLKS - 1 : 0);

  logic [IW-1:0] intervalCnt;
  logic [DW-1:0] debtCnt;
  logic [WW-1:0] waitCnt;
  logic          tick;

  assign tick = !strobe.holdClear && (intervalCnt == INT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.holdClear) intervalCnt <= '0;
    else if (tick)                 intervalCnt <= '0;
    else                           intervalCnt <= intervalCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.holdClear) begin
      debtCnt <= '0;
    end else if (tick && !strobe.debtDec) begin
      if (debtCnt != DEBT_TOP) debtCnt <= debtCnt + 1'b1;
    end else if (!tick && strobe.debtDec) begin
      debtCnt <= debtCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else begin
      case (strobe.waitLoad)
        WAIT_TRP:  waitCnt <= LOAD_TRP;
        WAIT_TRC:  waitCnt <= LOAD_TRC;
        WAIT_EXIT: waitCnt <= LOAD_EXIT;
        default:   if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      endcase
    end
  end

  assign debtPending = (debtCnt != '0);
  assign debtFull    = (debtCnt == DEBT_TOP);
  assign waitDone    = (waitCnt == '0);

  assert_debt_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    debtCnt <= DEBT_TOP);

  assert_no_repay_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.debtDec |-> (debtCnt != '0));

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int unsigned TRP_CLKS = 3,
  parameter int unsigned TRC_CLKS = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyBankOpen,
  input  logic        sleepReq,
  input  logic        cmdGrant,
  input  logic        debtPending,
  input  logic        waitDone,
  output logic        cmdReq,
  output cmdKind_e    cmdKind,
  output logic        ckeOut,
  output logic        accessOk,
  output ctlStrobes_t strobe
);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_REQ, S_PRE_WAIT, S_REF_REQ, S_REF_WAIT,
    S_SR_REQ, S_SR_ON, S_SR_EXIT, S_EXIT_REF
  } state_e;

  state_e state, stateNxt;
  logic   issue;

  assign issue = cmdReq && cmdGrant;

  always_comb begin
    stateNxt         = state;
    cmdReq           = 1'b0;
    cmdKind          = KIND_NONE;
    ckeOut           = 1'b1;
    accessOk         = 1'b0;
    strobe.debtDec   = 1'b0;
    strobe.holdClear = 1'b0;
    strobe.waitLoad  = WAIT_NONE;
    case (state)
      S_IDLE: begin
        accessOk = 1'b1;
        if (sleepReq)         stateNxt = anyBankOpen ? S_PRE_REQ : S_SR_REQ;
        else if (debtPending) stateNxt = anyBankOpen ? S_PRE_REQ : S_REF_REQ;
      end
      S_PRE_REQ: begin
        accessOk = 1'b1;
        cmdReq   = 1'b1;
        cmdKind  = KIND_PREA;
        if (cmdGrant) begin
          stateNxt        = S_PRE_WAIT;
          strobe.waitLoad = WAIT_TRP;
        end else if (!anyBankOpen || (!sleepReq && !debtPending)) begin
          stateNxt = S_IDLE;
        end
      end
      S_PRE_WAIT: if (waitDone) stateNxt = S_IDLE;
      S_REF_REQ: begin
        accessOk = 1'b1;
        cmdReq   = !anyBankOpen;
        cmdKind  = KIND_REF;
        if (cmdGrant && !anyBankOpen) begin
          stateNxt        = S_REF_WAIT;
          strobe.waitLoad = WAIT_TRC;
          strobe.debtDec  = 1'b1;
        end else if (anyBankOpen || sleepReq) begin
          stateNxt = S_IDLE;
        end
      end
      S_REF_WAIT: if (waitDone) stateNxt = S_IDLE;
      S_SR_REQ: begin
        accessOk = 1'b1;
        cmdReq   = !anyBankOpen;
        cmdKind  = KIND_SRE;
        if (cmdGrant && !anyBankOpen) begin
          ckeOut   = 1'b0;
          stateNxt = S_SR_ON;
        end else if (anyBankOpen || !sleepReq) begin
          stateNxt = S_IDLE;
        end
      end
      S_SR_ON: begin
        ckeOut           = 1'b0;
        strobe.holdClear = 1'b1;
        if (!sleepReq) begin
          stateNxt        = S_SR_EXIT;
          strobe.waitLoad = WAIT_EXIT;
        end
      end
      S_SR_EXIT: begin
        strobe.holdClear = 1'b1;
        if (waitDone) stateNxt = S_EXIT_REF;
      end
      S_EXIT_REF: begin
        strobe.holdClear = 1'b1;
        cmdReq           = 1'b1;
        cmdKind          = KIND_REF;
        if (cmdGrant) begin
          stateNxt        = S_REF_WAIT;
          strobe.waitLoad = WAIT_TRC;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  // spacing monitors for the assertions below
  localparam int GW = $clog2(TRC_CLKS + TRP_CLKS + 2) + 1;
  localparam logic [GW-1:0] G_TOP = '1;
  localparam logic [GW-1:0] G_TRP = GW'(TRP_CLKS);
  localparam logic [GW-1:0] G_TRC = GW'(TRC_CLKS);

  logic [GW-1:0] sincePrea, sinceRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sincePrea <= G_TOP;
      sinceRef  <= G_TOP;
    end else begin
      if (issue && cmdKind == KIND_PREA) sincePrea <= GW'(1);
      else if (sincePrea != G_TOP)       sincePrea <= sincePrea + 1'b1;
      if (issue && cmdKind == KIND_REF)  sinceRef <= GW'(1);
      else if (sinceRef != G_TOP)        sinceRef <= sinceRef + 1'b1;
    end
  end

  assert_trp_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issue && (cmdKind == KIND_REF || cmdKind == KIND_SRE)) |-> (sincePrea >= G_TRP));

  assert_trc_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issue || accessOk) |-> (sinceRef >= G_TRC));

  assert_cke_drop_with_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeOut && $past(ckeOut)) |-> (issue && cmdKind == KIND_SRE));

  assert_quiet_in_selfref_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeOut && !cmdGrant) |-> (!accessOk && !cmdReq));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned REFI_NS  = 15625,
  parameter int unsigned TRP_NS   = 20,
  parameter int unsigned TRC_NS   = 65,
  parameter int unsigned DEBT_MAX = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyBankOpen,
  input  logic       sleepReq,
  input  logic       cmdGrant,
  output logic       cmdReq,
  output logic [1:0] cmdKind,
  output logic       refUrgent,
  output logic       ckeOut,
  output logic       accessOk
);

  localparam int unsigned INTERVAL_CLKS = (REFI_NS * CLK_MHZ) / 1000;
  localparam int unsigned TRP_CLKS      = ceilClks(TRP_NS, CLK_MHZ);
  localparam int unsigned TRC_CLKS      = ceilClks(TRC_NS, CLK_MHZ);

  ctlStrobes_t strobe;
  cmdKind_e    kindInt;
  logic        debtPending, waitDone;

  refsched_ctrl #(.TRP_CLKS(TRP_CLKS), .TRC_CLKS(TRC_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .anyBankOpen(anyBankOpen), .sleepReq(sleepReq),
    .cmdGrant(cmdGrant), .debtPending(debtPending), .waitDone(waitDone),
    .cmdReq(cmdReq), .cmdKind(kindInt), .ckeOut(ckeOut), .accessOk(accessOk),
    .strobe(strobe)
  );

  refsched_timers #(
    .INTERVAL_CLKS(INTERVAL_CLKS), .DEBT_MAX(DEBT_MAX),
    .TRP_CLKS(TRP_CLKS), .TRC_CLKS(TRC_CLKS)
  ) uTimers (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .debtPending(debtPending), .debtFull(refUrgent), .waitDone(waitDone)
  );

  assign cmdKind = kindInt;

endmodule

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;

  localparam int INT = (15625 * 125) / 1000;
  localparam int TRP = (20 * 125 + 999) / 1000;
  localparam int TRC = (65 * 125 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       anyBankOpen = 1'b0;
  logic       sleepReq = 1'b0;
  logic       cmdGrant = 1'b0;
  logic       cmdReq, refUrgent, ckeOut, accessOk;
  logic [1:0] cmdKind;

  int nVec = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  refresh_scheduler dut (
    .clk(clk), .rstN(rstN), .anyBankOpen(anyBankOpen), .sleepReq(sleepReq),
    .cmdGrant(cmdGrant), .cmdReq(cmdReq), .cmdKind(cmdKind),
    .refUrgent(refUrgent), .ckeOut(ckeOut), .accessOk(accessOk)
  );

  task automatic check(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    nVec++;
    if (act < lo || act > hi) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // wait at falling edges for a request, returns samples waited
  task automatic waitReq(input int limit, output int n);
    n = 0;
    while (!cmdReq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // grant the pending request, return samples until accessOk
  task automatic grantAndTime(output int n);
    cmdGrant = 1'b1;
    @(negedge clk);
    cmdGrant = 1'b0;
    n = 1;
    while (!accessOk && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 cmdReq in reset", cmdReq, 0);
    check("R1 cmdKind in reset", cmdKind, 0);
    check("R1 refUrgent in reset", refUrgent, 0);
    check("R1 ckeOut in reset", ckeOut, 1);
    check("R1 accessOk in reset", accessOk, 1);
    rstN = 1'b1;
  endtask

  task automatic testFirstRefresh();
    int n;
    waitReq(INT + 10, n);
    checkRange("R2 first request delay", n, INT, INT + 2);
    check("R2 first request kind", cmdKind, 2);
  endtask

  task automatic testTrc();
    int n;
    cmdGrant = 1'b1;
    @(negedge clk);
    cmdGrant = 1'b0;
    check("R5 accessOk low after refresh", accessOk, 0);
    check("R5 no request after refresh", cmdReq, 0);
    n = 1;
    while (!accessOk && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R5 accessOk return", n, TRC);
    @(negedge clk);
    check("R6 no request with no debt", cmdReq, 0);
  endtask

  task automatic testPrechargeFirst();
    int n;
    anyBankOpen = 1'b1;
    waitReq(INT + 10, n);
    check("R3 kind with bank open", cmdKind, 1);
    cmdGrant = 1'b1;
    @(negedge clk);
    cmdGrant = 1'b0;
    anyBankOpen = 1'b0;
    n = 1;
    while (!cmdReq && n < 100) begin
      @(negedge clk);
      n++;
    end
    checkRange("R4 precharge to refresh gap", n, TRP, TRP + 1);
    check("R3 refresh after precharge kind", cmdKind, 2);
    grantAndTime(n);
    check("R5 accessOk return after second refresh", n, TRC);
  endtask

  task automatic testDebt();
    int n;
    int grants;
    n = 0;
    while (!refUrgent && n < 9 * INT) begin
      @(negedge clk);
      n++;
      if (n == 7 * INT) check("R6 urgent still low at 7 intervals", refUrgent, 0);
    end
    checkRange("R6 urgent after eight owed", n, 7 * INT + 1, 8 * INT);
    repeat (INT + 10) @(negedge clk);
    check("R6 request held while postponed", cmdReq, 1);
    check("R6 postponed request kind", cmdKind, 2);
    grants = 0;
    for (int i = 0; i < 20; i++) begin
      if (!cmdReq) break;
      grantAndTime(n);
      grants++;
      if (grants == 1) check("R6 urgent clears after one repay", refUrgent, 0);
      repeat (2) @(negedge clk);
    end
    check("R6 refreshes owed after saturation", grants, 8);
  endtask

  task automatic testSelfRefresh();
    int n;
    int bad;
    sleepReq = 1'b1;
    anyBankOpen = 1'b1;
    waitReq(20, n);
    check("R3 sleep with bank open asks precharge", cmdKind, 1);
    cmdGrant = 1'b1;
    @(negedge clk);
    cmdGrant = 1'b0;
    anyBankOpen = 1'b0;
    waitReq(20, n);
    check("R7 entry kind", cmdKind, 3);
    check("R7 cke high before grant", ckeOut, 1);
    cmdGrant = 1'b1;
    #1;
    check("R7 cke low in grant cycle", ckeOut, 0);
    @(negedge clk);
    cmdGrant = 1'b0;
    bad = 0;
    for (int i = 0; i < 3000; i++) begin
      if (cmdReq || ckeOut || accessOk) bad++;
      @(negedge clk);
    end
    check("R7 quiet and cke low in self refresh", bad, 0);
    sleepReq = 1'b0;
    @(negedge clk);
    check("R8 cke high after release", ckeOut, 1);
    n = 0;
    while (!cmdReq && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R8 exit refresh delay", n, TRC);
    check("R8 exit refresh kind", cmdKind, 2);
    check("R8 access held during exit", accessOk, 0);
    grantAndTime(n);
    check("R8 access after exit refresh", n, TRC);
    @(negedge clk);
    check("R8 no owed refresh after exit", cmdReq, 0);
  endtask

  initial begin
    testReset();
    testFirstRefresh();
    testTrc();
    testPrechargeFirst();
    testDebt();
    testSelfRefresh();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nBad++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule